// File: doc/BRIEF.md
# Bus Handoff Arbiter

This block arbitrates ownership of a shared bus between a processor and a set of external masters. The external masters take part through three wires. The first is an active-low request, the wire-OR of every requester. The second is an active-low grant that this block drives back. The third is an active-low acknowledge, which a new master asserts once it has taken the bus. External requesters always outrank the processor. A request therefore leads to a grant, but only after any processor bus cycle already in progress has finished.

The block also tells the processor core to stop starting new bus cycles from the moment a request is accepted until ownership comes back. It drives a bus-owned flag that controls the processor's tri-state drivers. A requester may drop its request before it acknowledges, either because of a glitch or because it no longer needs the bus. In that case the grant is taken back and the processor keeps the bus. When a master releases the bus while another request is pending, the block offers the bus again without letting the processor run a cycle in between.

Top module: `bus_handoff_arbiter`

## Requirements
- R1: After synchronous reset, bus_grant_n is 1, bus_owned is 1 and cpu_stall is 0.
- R2: With no processor cycle busy, a low level on bus_req_n asserts bus_grant_n low, drives bus_owned low and drives cpu_stall high.
- R3: While cpu_cycle_busy is 1, an accepted request keeps bus_grant_n high and bus_owned high and raises cpu_stall. The grant is asserted on the first clock edge after cpu_cycle_busy falls.
- R4: A low level on bus_ack_n during a grant negates bus_grant_n while bus_owned stays 0 and cpu_stall stays 1, even when the request is dropped at the same time.
- R5: While bus_ack_n stays low, bus_grant_n stays 1 and bus_owned stays 0, whatever bus_req_n does.
- R6: When bus_ack_n rises with no request pending, bus_owned returns to 1 with cpu_stall still 1 for one cycle, and cpu_stall falls on the next cycle.
- R7: When bus_ack_n rises while bus_req_n is low, the block spends one cycle with bus_owned 1, then grants again with cpu_stall held high throughout.
- R8: If bus_req_n rises while the grant is asserted and no acknowledge has arrived, bus_grant_n returns to 1, bus_owned to 1 and cpu_stall to 0.
- R9: bus_req_n and bus_ack_n pass through a SYNC_STAGES-deep synchronizer (default 2). A change on either pin first shows on the outputs at the third rising clock edge after it, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_n | input | 1 | Wire-ORed bus request, active low, asynchronous |
| bus_ack_n | input | 1 | Grant acknowledge from the new master, active low, asynchronous |
| cpu_cycle_busy | input | 1 | High while a processor bus cycle is in progress |
| bus_grant_n | output | 1 | Bus grant, active low |
| cpu_stall | output | 1 | Tells the processor core not to start new bus cycles |
| bus_owned | output | 1 | High while the processor may drive the bus |

## Verification
The hardest situation to reach from the ports is a second request that is already waiting when the first master lets go of acknowledge. The release cycle must then move straight into a fresh grant, without ever dropping cpu_stall. The bench reaches it by holding bus_req_n low for the whole time acknowledge is asserted, as a second requester would. It repeats this for several hold lengths, and it also sweeps the length of the processor cycle that the first request must wait out. The withdrawn-request path is reached by raising bus_req_n while the grant is out and before any acknowledge.

// File: rtl/bha_pkg.sv
package bha_pkg;
  typedef enum logic [1:0] {
    ARB_PROC   = 2'd0,  // processor holds the bus
    ARB_OFFER  = 2'd1,  // grant out, awaiting acknowledge
    ARB_HANDED = 2'd2,  // external master holds the bus
    ARB_RETURN = 2'd3   // master let go, processor has the bus back
  } arb_state_e;

  localparam int unsigned IN_COUNT = 2;
  localparam int unsigned IDX_REQ  = 0;
  localparam int unsigned IDX_ACK  = 1;
endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= {WIDTH{IDLE}};
    else     chain[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= {WIDTH{IDLE}};
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
  import bha_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ack,
  input  logic cyc_busy,
  output logic grant_n_o,
  output logic stall_o,
  output logic owned_o
);
  arb_state_e st_q, st_d;
  logic       gnt_n_q, stall_q, own_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARB_PROC:   if (req && !cyc_busy) st_d = ARB_OFFER;
      ARB_OFFER:  if (ack)              st_d = ARB_HANDED;
                  else if (!req)        st_d = ARB_PROC;
      ARB_HANDED: if (!ack)             st_d = ARB_RETURN;
      ARB_RETURN: if (req)              st_d = ARB_OFFER;
                  else                  st_d = ARB_PROC;
      default:                          st_d = ARB_PROC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ARB_PROC;
      gnt_n_q <= 1'b1;
      stall_q <= 1'b0;
      own_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      gnt_n_q <= (st_d != ARB_OFFER);
      stall_q <= (st_d != ARB_PROC) || req;
      own_q   <= (st_d == ARB_PROC) || (st_d == ARB_RETURN);
    end
  end

  assign grant_n_o = gnt_n_q;
  assign stall_o   = stall_q;
  assign owned_o   = own_q;

  a_r3_no_grant_in_cycle: assert property (@(posedge clk) disable iff (rst)
    (st_q == ARB_PROC && cyc_busy) |=> gnt_n_q);
  a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
    $fell(gnt_n_q) |-> $past(req));
  a_r4_ack_drops_grant: assert property (@(posedge clk) disable iff (rst)
    (st_q == ARB_OFFER && ack) |=> (gnt_n_q && !own_q && stall_q));
  a_r5_hold_while_ack: assert property (@(posedge clk) disable iff (rst)
    (st_q == ARB_HANDED && ack) |=> (gnt_n_q && !own_q));
  a_r8_withdraw: assert property (@(posedge clk) disable iff (rst)
    (st_q == ARB_OFFER && !req && !ack) |=> (own_q && !stall_q && gnt_n_q));
endmodule

// File: rtl/bus_handoff_arbiter.sv
module bus_handoff_arbiter
  import bha_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_req_n,
  input  logic bus_ack_n,
  input  logic cpu_cycle_busy,
  output logic bus_grant_n,
  output logic cpu_stall,
  output logic bus_owned
);
  logic [IN_COUNT-1:0] raw_n, synced_n;

  assign raw_n[IDX_REQ] = bus_req_n;
  assign raw_n[IDX_ACK] = bus_ack_n;

  bha_sync #(.WIDTH(IN_COUNT), .STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_n),
    .sync_o  (synced_n)
  );

  bha_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (!synced_n[IDX_REQ]),
    .ack       (!synced_n[IDX_ACK]),
    .cyc_busy  (cpu_cycle_busy),
    .grant_n_o (bus_grant_n),
    .stall_o   (cpu_stall),
    .owned_o   (bus_owned)
  );

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (bus_grant_n && bus_owned && !cpu_stall));
endmodule

// File: tb/bus_handoff_arbiter_tb.sv
`timescale 1ns/1ps
module bus_handoff_arbiter_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic req_n = 1'b1, ack_n = 1'b1, busy = 1'b0;
  logic gnt_n, stall, owned;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_handoff_arbiter u_dut (
    .clk(clk), .rst(rst), .bus_req_n(req_n), .bus_ack_n(ack_n),
    .cpu_cycle_busy(busy), .bus_grant_n(gnt_n), .cpu_stall(stall),
    .bus_owned(owned)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // expected packed as {grant_n, owned, stall}
  task automatic chk(input string tag, input logic [2:0] exp);
    checks++;
    if ({gnt_n, owned, stall} !== exp) begin
      fails++;
      $display("FAIL %s: got {gnt_n,own,stall}=%b expected %b at %0t",
               tag, {gnt_n, owned, stall}, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 reset", 3'b110);
    for (int b = 0; b <= 4; b++) begin
      // normal handoff, processor cycle of length b
      busy  = (b > 0);
      req_n = 1'b0;
      tick(2);
      chk("R9 not before third edge", 3'b110);
      tick(1);
      if (b > 0) begin
        chk("R3 held during cycle", 3'b111);
        for (int k = 0; k < b; k++) begin
          tick(1);
          chk("R3 still held", 3'b111);
        end
        busy = 1'b0;
        tick(1);
        chk("R3 grant after cycle", 3'b001);
      end else begin
        chk("R2 immediate grant", 3'b001);
      end
      ack_n = 1'b0; req_n = 1'b1;
      tick(3);
      chk("R4 ack drops grant", 3'b101);
      tick(b + 1);
      chk("R5 held while ack", 3'b101);
      ack_n = 1'b1;
      tick(3);
      chk("R6 return cycle", 3'b111);
      tick(1);
      chk("R6 stall released", 3'b110);

      // withdrawn request
      req_n = 1'b0;
      tick(3);
      chk("R2 grant", 3'b001);
      req_n = 1'b1;
      tick(2);
      chk("R9 withdraw latency", 3'b001);
      tick(1);
      chk("R8 withdrawn", 3'b110);

      // back-to-back: second requester holds request through ack
      req_n = 1'b0;
      tick(3);
      chk("R2 grant b2b", 3'b001);
      ack_n = 1'b0;
      tick(3);
      chk("R5 ack with req low", 3'b101);
      tick(b + 1);
      chk("R5 still held", 3'b101);
      ack_n = 1'b1;
      tick(3);
      chk("R7 return cycle", 3'b111);
      tick(1);
      chk("R7 regrant", 3'b001);
      ack_n = 1'b0; req_n = 1'b1;
      tick(3);
      chk("R4 second ack", 3'b101);
      ack_n = 1'b1;
      tick(3);
      chk("R6 second return", 3'b111);
      tick(1);
      chk("R6 idle", 3'b110);
    end
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    tick(1);
    chk("R1 re-reset", 3'b110);
    done = 1;
    finish_run();
  end
endmodule